// File: doc/BRIEF.md
# Indexed Control Register Port Decoder

This block sits on a byte-wide I/O bus and gives access to four banks of control registers through a small set of port addresses. Three of the banks are ordinary indexed banks: the sequencer, the graphics bank and the CRT bank. For each of these, a write to the bank's index port picks an internal register number. A write to the port one address above then stores into that register. The index stays in place until it is written again, so a loop can keep writing the data port without touching the index.

The fourth bank holds the attribute registers. Its index and its data share one write port, and an internal toggle decides which one a write goes to. Reading the input status port returns the toggle to index mode. Bit 5 of an attribute index write is kept as a separate video-enable flag. While that flag is 0, the sixteen palette entries can be written and the video is a flat colour. While it is 1, the palette is locked and normal video is shown.

A 16-bit word write counts as two byte writes in one cycle: the low byte goes to the addressed port and the high byte to the next port. This shortcut is suppressed wherever the shared attribute port is involved. The CRT bank and the status port move between the 3Dx range and the 3Bx range according to a colour/monochrome select pin. Every register's contents are driven out on flat output vectors for the display logic.

Top module: `ioreg_port_top`

## Requirements
- R1: A write to an ordinary bank's index port (sequencer 0x3C4, graphics 0x3CE, CRT 0x3D4 or 0x3B4) stores the 8-bit index. A read of the same port returns that index.
- R2: A write to the port at index+1 stores the byte into the selected register. The new value appears on the register output vector (register k at bits 8k+7..8k) after the next clock edge, and a read of the data port returns it.
- R3: A bank's index is not changed by data writes, so repeated data-port writes all land in the same register.
- R4: When the index is outside a bank's register count (sequencer 5, graphics 9 with index 8 the bit mask and index 5 the mode, CRT 25), the data port reads 0 and writes to it change nothing.
- R5: A word write (io_word=1) to an index port stores the low byte as the index. In the same cycle it stores the high byte into the register that this new index selects.
- R6: Writes to the attribute port 0x3C0 alternate. The first write after reset or after a toggle clear is taken as the index, the next as data. A read of 0x3C1 returns the selected attribute register (21 registers).
- R7: Any read of the status port (0x3DA in colour mode, 0x3BA in monochrome mode) returns the attribute toggle to index mode. The status port reads as 0.
- R8: Bits 4..0 of an attribute index write select the register and bit 5 is held as the video-enable flag. video_on_o equals that flag and pal_access_o equals its inverse. A read of 0x3C0 returns {2'b00, flag, index}.
- R9: Attribute registers 0..15 (the palette) accept data only while the flag is 0. Registers 16..20 accept data regardless of the flag.
- R10: A word write that touches the attribute port writes only its low byte and flips the toggle once.
- R11: With colour_sel=1 the CRT bank answers at 0x3D4/0x3D5. With colour_sel=0 it answers at 0x3B4/0x3B5, and the other range neither reads nor writes it.
- R12: Reset clears all indices, all registers and the video-enable flag, and puts the attribute toggle in index mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| colour_sel | input | 1 | 1 puts the CRT bank and status port in the 3Dx range, 0 in the 3Bx range |
| io_addr | input | 10 | Port address |
| io_wr | input | 1 | Write strobe |
| io_word | input | 1 | Write is 16 bits: low byte to io_addr, high byte to io_addr+1 |
| io_rd | input | 1 | Read strobe |
| io_wdata | input | 16 | Write data (the high byte is used only for word writes) |
| io_rdata | output | 8 | Read data, combinational, 0 when not reading |
| seq_regs_o | output | 40 | Sequencer registers, flat |
| gfx_regs_o | output | 72 | Graphics registers, flat |
| crt_regs_o | output | 200 | CRT registers, flat |
| attr_regs_o | output | 168 | Attribute registers, flat |
| video_on_o | output | 1 | Attribute index bit 5 flag |
| pal_access_o | output | 1 | Palette writes allowed (inverse of the flag) |

## Verification
Writes take effect at the rising edge that samples io_wr. Register outputs and read-back therefore change one cycle after the write is presented. Reads are combinational and are valid in the same cycle as io_rd. The toggle clear caused by a status read lands at the edge that ends that read, so it affects the next attribute write. The bench drives every operation on a falling edge and samples io_rdata 2 ns later in the same low phase. Every write has had its edge before the next operation's sample is taken.

// File: rtl/ioreg_pkg.sv
package ioreg_pkg;
  localparam int DW        = 8;
  localparam int AW        = 10;
  localparam int SEQ_N     = 5;
  localparam int GFX_N     = 9;
  localparam int CRT_N     = 25;
  localparam int ATTR_N    = 21;
  localparam int PAL_N     = 16;
  localparam int NBANK     = 3;
  localparam logic [AW-1:0] P_SEQ_IDX  = 10'h3C4;
  localparam logic [AW-1:0] P_GFX_IDX  = 10'h3CE;
  localparam logic [AW-1:0] P_CRT_COL  = 10'h3D4;
  localparam logic [AW-1:0] P_CRT_MONO = 10'h3B4;
  localparam logic [AW-1:0] P_ATTR_WR  = 10'h3C0;
  localparam logic [AW-1:0] P_ATTR_RD  = 10'h3C1;
  localparam logic [AW-1:0] P_STS_COL  = 10'h3DA;
  localparam logic [AW-1:0] P_STS_MONO = 10'h3BA;
endpackage

// File: rtl/idx_bank.sv
module idx_bank #(
  parameter int NREG = 9,
  parameter int DW   = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               idx_we,
  input  logic [DW-1:0]      idx_wd,
  input  logic               dat_we,
  input  logic [DW-1:0]      dat_wd,
  output logic [DW-1:0]      idx_q,
  output logic [DW-1:0]      sel_q,
  output logic [NREG*DW-1:0] regs_o
);
  logic [DW-1:0] target;
  assign target = idx_we ? idx_wd : idx_q;

  always_ff @(posedge clk) begin
    if (!rst_n)      idx_q <= '0;
    else if (idx_we) idx_q <= idx_wd;
  end

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    always_ff @(posedge clk) begin
      if (!rst_n)
        regs_o[g*DW +: DW] <= '0;
      else if (dat_we && target == DW'(g))
        regs_o[g*DW +: DW] <= dat_wd;
    end
  end

  always_comb begin
    sel_q = '0;
    for (int k = 0; k < NREG; k++)
      if (idx_q == DW'(k)) sel_q = regs_o[k*DW +: DW];
  end

  // R3: only an index write may move the index
  p_idx_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !idx_we |=> $stable(idx_q));
  // R4: out-of-range data write leaves every register alone
  p_oor_ignored_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (dat_we && !idx_we && idx_q >= DW'(NREG)) |=> $stable(regs_o));
endmodule

// File: rtl/attr_bank.sv
module attr_bank #(
  parameter int NREG = 21,
  parameter int NPAL = 16,
  parameter int DW   = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr,
  input  logic [DW-1:0]      wd,
  input  logic               clr,
  output logic [DW-1:0]      idx_rd,
  output logic [DW-1:0]      sel_q,
  output logic [NREG*DW-1:0] regs_o,
  output logic               video_on
);
  localparam int IW = 5;
  logic          data_ph;
  logic [IW-1:0] idx_q;
  logic          dat_ok;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      data_ph  <= 1'b0;
      idx_q    <= '0;
      video_on <= 1'b0;
    end else begin
      if (clr)     data_ph <= 1'b0;
      else if (wr) data_ph <= ~data_ph;
      if (wr && !data_ph) begin
        idx_q    <= wd[IW-1:0];
        video_on <= wd[IW];
      end
    end
  end

  assign dat_ok = wr && data_ph && (idx_q >= IW'(NPAL) || !video_on);

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    always_ff @(posedge clk) begin
      if (!rst_n)
        regs_o[g*DW +: DW] <= '0;
      else if (dat_ok && idx_q == IW'(g))
        regs_o[g*DW +: DW] <= wd;
    end
  end

  always_comb begin
    sel_q = '0;
    for (int k = 0; k < NREG; k++)
      if (idx_q == IW'(k)) sel_q = regs_o[k*DW +: DW];
  end
  assign idx_rd = {2'b00, video_on, idx_q};

  // R7: a status read always returns the toggle to index mode
  p_status_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> !data_ph);
  // R6: a write in index mode moves to data mode
  p_toggle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && !data_ph && !clr) |=> data_ph);
  // R9: palette locked while the video flag is set
  p_pal_locked_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && data_ph && video_on && idx_q < IW'(NPAL)) |=> $stable(regs_o[NPAL*DW-1:0]));
endmodule

// File: rtl/ioreg_port_top.sv
module ioreg_port_top
  import ioreg_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  colour_sel,
  input  logic [AW-1:0]         io_addr,
  input  logic                  io_wr,
  input  logic                  io_word,
  input  logic                  io_rd,
  input  logic [15:0]           io_wdata,
  output logic [DW-1:0]         io_rdata,
  output logic [SEQ_N*DW-1:0]   seq_regs_o,
  output logic [GFX_N*DW-1:0]   gfx_regs_o,
  output logic [CRT_N*DW-1:0]   crt_regs_o,
  output logic [ATTR_N*DW-1:0]  attr_regs_o,
  output logic                  video_on_o,
  output logic                  pal_access_o
);
  logic [AW-1:0] addr_hi, crt_base, sts_port;
  logic          wr_lo, wr_hi;
  logic [AW-1:0] base [NBANK];
  logic [NBANK-1:0] idx_we, dat_we, idx_hit_lo;
  logic [DW-1:0] idx_wd [NBANK];
  logic [DW-1:0] dat_wd [NBANK];
  logic [DW-1:0] idx_q  [NBANK];
  logic [DW-1:0] sel_q  [NBANK];
  logic [DW-1:0] a_idx_rd, a_sel;
  logic          sts_rd;

  assign addr_hi  = io_addr + AW'(1);
  assign crt_base = colour_sel ? P_CRT_COL : P_CRT_MONO;
  assign sts_port = colour_sel ? P_STS_COL : P_STS_MONO;
  assign base[0]  = P_SEQ_IDX;
  assign base[1]  = P_GFX_IDX;
  assign base[2]  = crt_base;
  assign wr_lo    = io_wr;
  assign wr_hi    = io_wr && io_word && io_addr != P_ATTR_WR && addr_hi != P_ATTR_WR;
  assign sts_rd   = io_rd && io_addr == sts_port;

  always_comb begin
    for (int b = 0; b < NBANK; b++) begin
      idx_hit_lo[b] = wr_lo && io_addr == base[b];
      idx_we[b] = idx_hit_lo[b] || (wr_hi && addr_hi == base[b]);
      idx_wd[b] = idx_hit_lo[b] ? io_wdata[7:0] : io_wdata[15:8];
      dat_we[b] = (wr_lo && io_addr == base[b] + AW'(1)) ||
                  (wr_hi && addr_hi == base[b] + AW'(1));
      dat_wd[b] = (wr_lo && io_addr == base[b] + AW'(1)) ? io_wdata[7:0] : io_wdata[15:8];
    end
  end

  idx_bank #(.NREG(SEQ_N), .DW(DW)) u_seq (
    .clk(clk), .rst_n(rst_n), .idx_we(idx_we[0]), .idx_wd(idx_wd[0]),
    .dat_we(dat_we[0]), .dat_wd(dat_wd[0]), .idx_q(idx_q[0]), .sel_q(sel_q[0]),
    .regs_o(seq_regs_o));
  idx_bank #(.NREG(GFX_N), .DW(DW)) u_gfx (
    .clk(clk), .rst_n(rst_n), .idx_we(idx_we[1]), .idx_wd(idx_wd[1]),
    .dat_we(dat_we[1]), .dat_wd(dat_wd[1]), .idx_q(idx_q[1]), .sel_q(sel_q[1]),
    .regs_o(gfx_regs_o));
  idx_bank #(.NREG(CRT_N), .DW(DW)) u_crt (
    .clk(clk), .rst_n(rst_n), .idx_we(idx_we[2]), .idx_wd(idx_wd[2]),
    .dat_we(dat_we[2]), .dat_wd(dat_wd[2]), .idx_q(idx_q[2]), .sel_q(sel_q[2]),
    .regs_o(crt_regs_o));
  attr_bank #(.NREG(ATTR_N), .NPAL(PAL_N), .DW(DW)) u_attr (
    .clk(clk), .rst_n(rst_n), .wr(wr_lo && io_addr == P_ATTR_WR),
    .wd(io_wdata[7:0]), .clr(sts_rd), .idx_rd(a_idx_rd), .sel_q(a_sel),
    .regs_o(attr_regs_o), .video_on(video_on_o));

  assign pal_access_o = ~video_on_o;

  always_comb begin
    io_rdata = '0;
    if (io_rd) begin
      if (io_addr == P_ATTR_WR)      io_rdata = a_idx_rd;
      else if (io_addr == P_ATTR_RD) io_rdata = a_sel;
      else
        for (int b = 0; b < NBANK; b++) begin
          if (io_addr == base[b])                 io_rdata = idx_q[b];
          else if (io_addr == base[b] + AW'(1))   io_rdata = sel_q[b];
        end
    end
  end

  // R1: one address hits at most one index port
  p_one_index_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(idx_hit_lo));
  // R7: status reads return zero
  p_status_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    sts_rd |-> io_rdata == '0);
  // R8: the palette access output mirrors the flag inversely
  p_pal_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
    pal_access_o != video_on_o);
endmodule

// File: tb/sim_ioreg_port_top.sv
module sim_ioreg_port_top;
  logic clk = 1'b0, rst_n = 1'b0, colour_sel = 1'b1;
  logic [9:0] io_addr = '0;
  logic io_wr = 1'b0, io_word = 1'b0, io_rd = 1'b0;
  logic [15:0] io_wdata = '0;
  logic [7:0] io_rdata;
  logic [39:0] seq_regs_o;
  logic [71:0] gfx_regs_o;
  logic [199:0] crt_regs_o;
  logic [167:0] attr_regs_o;
  logic video_on_o, pal_access_o;
  int errors = 0, checks = 0;
  logic done = 1'b0;

  always #10 clk = ~clk;

  ioreg_port_top u0 (.*);

  // op: 0 byte write, 1 word write, 2 read-check; {op, addr, data, expect, req}
  localparam int NV = 38;
  localparam logic [39:0] VEC [NV] = '{
    {2'd0, 10'h3C4, 16'h0002, 8'h00, 4'd1},   // R1 seq index 2
    {2'd2, 10'h3C4, 16'h0000, 8'h02, 4'd1},   // R1
    {2'd0, 10'h3C5, 16'h000F, 8'h00, 4'd2},   // R2
    {2'd2, 10'h3C5, 16'h0000, 8'h0F, 4'd2},   // R2
    {2'd0, 10'h3C5, 16'h000A, 8'h00, 4'd3},   // R3 same register
    {2'd2, 10'h3C5, 16'h0000, 8'h0A, 4'd3},   // R3
    {2'd2, 10'h3C4, 16'h0000, 8'h02, 4'd3},   // R3 index unchanged
    {2'd1, 10'h3CE, 16'hFF08, 8'h00, 4'd5},   // R5 bit mask via word
    {2'd2, 10'h3CF, 16'h0000, 8'hFF, 4'd5},   // R5
    {2'd2, 10'h3CE, 16'h0000, 8'h08, 4'd5},   // R5
    {2'd0, 10'h3CE, 16'h0009, 8'h00, 4'd4},   // R4 out of range
    {2'd0, 10'h3CF, 16'h0055, 8'h00, 4'd4},   // R4
    {2'd2, 10'h3CF, 16'h0000, 8'h00, 4'd4},   // R4 reads 0
    {2'd0, 10'h3CE, 16'h0008, 8'h00, 4'd4},   // R4
    {2'd2, 10'h3CF, 16'h0000, 8'hFF, 4'd4},   // R4 bit mask intact
    {2'd1, 10'h3D4, 16'h2A13, 8'h00, 4'd11},  // R11 colour CRT
    {2'd2, 10'h3D5, 16'h0000, 8'h2A, 4'd11},  // R11
    {2'd2, 10'h3DA, 16'h0000, 8'h00, 4'd7},   // R7 status reads 0
    {2'd0, 10'h3C0, 16'h0013, 8'h00, 4'd6},   // R6 index 0x13
    {2'd0, 10'h3C0, 16'h0005, 8'h00, 4'd6},   // R6 data
    {2'd2, 10'h3C1, 16'h0000, 8'h05, 4'd6},   // R6
    {2'd2, 10'h3C0, 16'h0000, 8'h13, 4'd8},   // R8
    {2'd0, 10'h3C0, 16'h0002, 8'h00, 4'd9},   // R9 palette 2, flag 0
    {2'd0, 10'h3C0, 16'h003F, 8'h00, 4'd9},   // R9
    {2'd2, 10'h3C1, 16'h0000, 8'h3F, 4'd9},   // R9
    {2'd0, 10'h3C0, 16'h0022, 8'h00, 4'd9},   // R9 palette 2, flag 1
    {2'd0, 10'h3C0, 16'h0011, 8'h00, 4'd9},   // R9 blocked
    {2'd2, 10'h3C1, 16'h0000, 8'h3F, 4'd9},   // R9
    {2'd2, 10'h3C0, 16'h0000, 8'h22, 4'd8},   // R8 flag in bit 5
    {2'd0, 10'h3C0, 16'h0034, 8'h00, 4'd7},   // R7 toggle -> data
    {2'd2, 10'h3DA, 16'h0000, 8'h00, 4'd7},   // R7 clear
    {2'd0, 10'h3C0, 16'h0031, 8'h00, 4'd7},   // R7 taken as index
    {2'd2, 10'h3C0, 16'h0000, 8'h31, 4'd7},   // R7
    {2'd1, 10'h3C0, 16'h7766, 8'h00, 4'd10},  // R10 data reg 0x11
    {2'd2, 10'h3C1, 16'h0000, 8'h66, 4'd10},  // R10 low byte only
    {2'd0, 10'h3C0, 16'h0030, 8'h00, 4'd10},  // R10 toggled once
    {2'd2, 10'h3C0, 16'h0000, 8'h30, 4'd10},  // R10
    {2'd2, 10'h3C1, 16'h0000, 8'h00, 4'd10}   // R10 reg 0x10 untouched
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic op(input logic [1:0] k, input logic [9:0] a, input logic [15:0] d,
                    input logic [7:0] e, input string req);
    @(negedge clk);
    io_addr = a; io_wdata = d;
    io_wr = (k != 2'd2); io_word = (k == 2'd1); io_rd = (k == 2'd2);
    if (k == 2'd2) begin
      #2;
      check(req, io_rdata, e);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R12 reset state
    check("R12", {7'd0, |seq_regs_o}, 8'h00);
    check("R12", {7'd0, |gfx_regs_o | |crt_regs_o | |attr_regs_o}, 8'h00);
    check("R12", {6'd0, video_on_o, pal_access_o}, 8'h01);
    op(2'd2, 10'h3C4, 0, 8'h00, "R12");
    for (int i = 0; i < NV; i++)
      op(VEC[i][39:38], VEC[i][37:28], VEC[i][27:12], VEC[i][11:4],
         $sformatf("R%0d", VEC[i][3:0]));
    op(2'd3, 10'h000, 0, 0, "");  // idle cycle
    io_wr = 0; io_rd = 0;
    #2;
    check("R2", seq_regs_o[2*8 +: 8], 8'h0A);
    check("R5", gfx_regs_o[8*8 +: 8], 8'hFF);
    check("R11", crt_regs_o[19*8 +: 8], 8'h2A);
    check("R9", attr_regs_o[2*8 +: 8], 8'h3F);
    check("R8", {6'd0, video_on_o, pal_access_o}, 8'h02);
    // R11 monochrome mapping
    colour_sel = 1'b0;
    op(2'd0, 10'h3B4, 16'h0001, 0, "R11");
    op(2'd0, 10'h3B5, 16'h0044, 0, "R11");
    op(2'd2, 10'h3B5, 0, 8'h44, "R11");
    op(2'd2, 10'h3D5, 0, 8'h00, "R11");
    op(2'd0, 10'h3D5, 16'h0099, 0, "R11");
    op(2'd2, 10'h3B5, 0, 8'h44, "R11");
    // R7 monochrome status port
    op(2'd0, 10'h3C0, 16'h0025, 0, "R7");
    op(2'd2, 10'h3BA, 0, 8'h00, "R7");
    op(2'd0, 10'h3C0, 16'h0024, 0, "R7");
    op(2'd2, 10'h3C0, 0, 8'h24, "R7");
    @(negedge clk);
    io_wr = 0; io_rd = 0;
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(20 * 5000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule